// File: doc/BRIEF.md
# Shared-Memory Multi-Channel Audio Delay Line

This block delays up to eight audio channels. Each channel has its own programmed sample count, and all channels share one sample memory. The memory is divided into regions that sit next to each other in channel-number order. Each region is exactly as long as its channel's delay. A pointer unit adds a per-channel position to the region base to find the slot a sample is written to. The sample stored in that slot one full region-length earlier is the delayed output.

Samples arrive one at a time, each with a channel index and a valid strobe. The delayed sample leaves on a registered output port together with the same channel index. The block checks each programmed configuration before adopting it. A configuration whose delays add up to less than half the usable memory keeps all 32 bits of every sample. A larger total keeps only the upper 18 bits, which doubles the number of slots. A configuration whose total reaches the limit is refused and the previous one stays in force.

With memory depth D (parameter `ADDR_W`, D = 2^ADDR_W) and N channels, the limit on the summed counts is D - 2N and the narrow threshold is half of that limit. With the defaults (D = 1024, N = 8) these are 1008 and 504.

Top module: `mc_delay_line`

## Requirements
- R1: A sample entering on channel k with programmed count n_k leaves the block when the (n_k+1)-th later sample of channel k enters. This holds once n_k+1 samples of that channel have entered since the configuration last changed.
- R2: A count of zero gives a delay of exactly one sample of that channel.
- R3: Samples of other channels arriving in any interleaving do not disturb the delayed stream of a channel.
- R4: While the sum of all counts is below half the limit (504 by default), `wide_mode` is 1 and the output carries all 32 bits of the stored sample.
- R5: While the sum is at or above half the limit but below the limit, `wide_mode` is 0. The output then carries the upper 18 bits of the stored sample in bits 31:14, and bits 13:0 are zero.
- R6: A configuration whose sum reaches the limit (1008 by default) sets `cfg_error` one clock later. The delays and width mode in force do not change. A later configuration below the limit is taken and clears `cfg_error`.
- R7: A sample presented with `in_valid` high before a rising edge appears with `out_valid` high and the same `out_ch` after the third rising edge. `out_valid` is never high without such a sample.
- R8: After reset `out_valid` and `cfg_error` are 0, `wide_mode` is 1, and all counts in force are zero. Memory contents are not cleared.
- R9: `cfg_delay` holds channel k's count in bits [16k+15:16k]. An accepted configuration that differs from the one in force takes effect at the next rising edge and restarts every channel's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_delay | input | NCH*CNT_W | Per-channel delay counts, channel 0 in the low field |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | CH_W | Channel of the input sample |
| in_data | input | SAMPLE_W | Input sample |
| out_valid | output | 1 | Delayed sample strobe |
| out_ch | output | CH_W | Channel of the delayed sample |
| out_data | output | SAMPLE_W | Delayed sample |
| wide_mode | output | 1 | 1 when samples are stored at full width |
| cfg_error | output | 1 | 1 while the last presented configuration was refused |

## Verification
The bench sets the zero-count case and a set of unequal counts with random channel interleaving. A design that mis-sized a region or took a base from the wrong neighbour would return another channel's data or a sample from the wrong age. The width threshold is tested one count below and at half the limit. An off-by-one compare would flip `wide_mode` and then truncate, or fail to truncate, the low 14 bits. The limit itself is tested at one below and exactly at the limit. A design that adopted the refused configuration would change the observed delays, and one that refused the boundary value would leave `cfg_error` high.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int DEF_SAMPLE_W = 32;
  localparam int DEF_STORE_W  = 18;
  localparam int DEF_CNT_W    = 16;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } mode_e;
endpackage

// File: rtl/dly_ram.sv
module dly_ram #(
  parameter int AW = 9,
  parameter int W  = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int WORDS = 1 << AW;

  logic [W-1:0] mem [WORDS];

  // read-first simple dual port: same-address read returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dly_cfg.sv
module dly_cfg #(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*CNT_W-1:0]  cfg_delay,
  output logic [NCH*SLOT_W-1:0] base_flat,
  output logic [NCH*SLOT_W-1:0] len_flat,
  output logic                  wide,
  output logic                  err,
  output logic                  restart
);
  localparam int DEPTH = 1 << SLOT_W;
  localparam int LIMIT = DEPTH - 2 * NCH;
  localparam int HALF  = LIMIT / 2;
  localparam int SUM_W = CNT_W + $clog2(NCH) + 1;

  logic [SUM_W-1:0]     pre [NCH+1];
  logic [SUM_W-1:0]     total;
  logic                 accept;
  logic [NCH*CNT_W-1:0] act_n;
  logic [SLOT_W-1:0]    base_r [NCH];
  logic [SLOT_W-1:0]    len_r  [NCH];

  always_comb begin
    pre[0] = '0;
    for (int k = 0; k < NCH; k++)
      pre[k+1] = pre[k] + SUM_W'(cfg_delay[k*CNT_W +: CNT_W]);
  end

  assign total   = pre[NCH];
  assign accept  = total < SUM_W'(LIMIT);
  assign restart = accept && (cfg_delay != act_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_n <= '0;
      wide  <= 1'b1;
      err   <= 1'b0;
      for (int k = 0; k < NCH; k++) begin
        base_r[k] <= SLOT_W'(k);
        len_r[k]  <= SLOT_W'(1);
      end
    end else begin
      err <= !accept;
      if (accept) begin
        act_n <= cfg_delay;
        wide  <= total < SUM_W'(HALF);
        for (int k = 0; k < NCH; k++) begin
          base_r[k] <= SLOT_W'(pre[k] + SUM_W'(k));
          len_r[k]  <= SLOT_W'(cfg_delay[k*CNT_W +: CNT_W]) + SLOT_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign base_flat[g*SLOT_W +: SLOT_W] = base_r[g];
    assign len_flat[g*SLOT_W +: SLOT_W]  = len_r[g];
  end

  logic [SLOT_W:0] region_end;
  assign region_end = {1'b0, base_r[NCH-1]} + {1'b0, len_r[NCH-1]};

  AST_REGION_FITS: assert property (@(posedge clk) disable iff (rst)
    wide ? (region_end <= (SLOT_W+1)'(DEPTH/2)) : (region_end <= (SLOT_W+1)'(DEPTH)))
    else $error("regions overrun memory"); // R4

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (err && $stable(act_n) && $stable(wide)))
    else $error("refused configuration altered state"); // R6
endmodule

// File: rtl/dly_ptr.sv
module dly_ptr #(
  parameter int NCH    = 8,
  parameter int SLOT_W = 10,
  parameter int CH_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  restart,
  input  logic                  adv,
  input  logic [CH_W-1:0]       adv_ch,
  input  logic [NCH*SLOT_W-1:0] base_flat,
  input  logic [NCH*SLOT_W-1:0] len_flat,
  output logic [SLOT_W-1:0]     slot
);
  logic [SLOT_W-1:0] base [NCH];
  logic [SLOT_W-1:0] len  [NCH];
  logic [SLOT_W-1:0] ptr  [NCH];
  logic [SLOT_W-1:0] nxt  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign base[g] = base_flat[g*SLOT_W +: SLOT_W];
    assign len[g]  = len_flat[g*SLOT_W +: SLOT_W];
    assign nxt[g]  = (ptr[g] + SLOT_W'(1) == len[g]) ? '0 : ptr[g] + SLOT_W'(1);

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      ptr[g] < len[g])
      else $error("position outside region"); // R1
  end

  assign slot = base[adv_ch] + ptr[adv_ch];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NCH; k++) begin
      if (rst || restart)
        ptr[k] <= '0;
      else if (adv && adv_ch == CH_W'(k))
        ptr[k] <= nxt[k];
    end
  end
endmodule

// File: rtl/mc_delay_line.sv
module mc_delay_line import dly_pkg::*; #(
  parameter int NCH      = 8,
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int STORE_W  = DEF_STORE_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int ADDR_W   = 10,
  localparam int CH_W    = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH*CNT_W-1:0] cfg_delay,
  input  logic                 in_valid,
  input  logic [CH_W-1:0]      in_ch,
  input  logic [SAMPLE_W-1:0]  in_data,
  output logic                 out_valid,
  output logic [CH_W-1:0]      out_ch,
  output logic [SAMPLE_W-1:0]  out_data,
  output logic                 wide_mode,
  output logic                 cfg_error
);
  localparam int LO_W    = SAMPLE_W - STORE_W;
  localparam int BANK_AW = ADDR_W - 1;

  logic [NCH*ADDR_W-1:0] base_flat, len_flat;
  logic                  restart;
  logic [ADDR_W-1:0]     slot;

  dly_cfg #(.NCH(NCH), .CNT_W(CNT_W), .SLOT_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay),
    .base_flat(base_flat), .len_flat(len_flat),
    .wide(wide_mode), .err(cfg_error), .restart(restart)
  );

  dly_ptr #(.NCH(NCH), .SLOT_W(ADDR_W), .CH_W(CH_W)) u_ptr (
    .clk(clk), .rst(rst), .restart(restart),
    .adv(in_valid), .adv_ch(in_ch),
    .base_flat(base_flat), .len_flat(len_flat), .slot(slot)
  );

  // stage 1: slot resolved
  logic                s1_v;
  logic [CH_W-1:0]     s1_ch;
  logic [SAMPLE_W-1:0] s1_data;
  logic [ADDR_W-1:0]   s1_slot;
  mode_e               s1_mode;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_ch   <= in_ch;
    s1_data <= in_data;
    s1_slot <= slot;
    s1_mode <= wide_mode ? MODE_WIDE : MODE_NARROW;
  end

  // bank mapping: wide uses both banks at one address, narrow packs by slot lsb
  logic [BANK_AW-1:0]  bank_addr;
  logic                we_hi, we_lo;
  logic [STORE_W-1:0]  wd_hi, wd_lo, rd_hi, rd_lo;

  always_comb begin
    wd_hi = s1_data[SAMPLE_W-1 -: STORE_W];
    if (s1_mode == MODE_WIDE) begin
      bank_addr = s1_slot[BANK_AW-1:0];
      we_hi     = s1_v;
      we_lo     = s1_v;
      wd_lo     = STORE_W'(s1_data[LO_W-1:0]);
    end else begin
      bank_addr = s1_slot[ADDR_W-1:1];
      we_hi     = s1_v && !s1_slot[0];
      we_lo     = s1_v && s1_slot[0];
      wd_lo     = s1_data[SAMPLE_W-1 -: STORE_W];
    end
  end

  dly_ram #(.AW(BANK_AW), .W(STORE_W)) u_bank_hi (
    .clk(clk), .we(we_hi), .waddr(bank_addr), .wdata(wd_hi),
    .raddr(bank_addr), .rdata(rd_hi)
  );

  dly_ram #(.AW(BANK_AW), .W(STORE_W)) u_bank_lo (
    .clk(clk), .we(we_lo), .waddr(bank_addr), .wdata(wd_lo),
    .raddr(bank_addr), .rdata(rd_lo)
  );

  // stage 2: memory word available
  logic            s2_v;
  logic [CH_W-1:0] s2_ch;
  mode_e           s2_mode;
  logic            s2_sel;

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    s2_ch   <= s1_ch;
    s2_mode <= s1_mode;
    s2_sel  <= s1_slot[0];
  end

  logic [SAMPLE_W-1:0] fmt;
  always_comb begin
    if (s2_mode == MODE_WIDE)
      fmt = {rd_hi, rd_lo[LO_W-1:0]};
    else
      fmt = {(s2_sel ? rd_lo : rd_hi), {LO_W{1'b0}}};
  end

  mode_e out_mode;
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
      out_mode  <= MODE_WIDE;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        out_ch   <= s2_ch;
        out_data <= fmt;
        out_mode <= s2_mode;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 (out_valid && out_ch == $past(in_ch, 3)))
    else $error("output timing or channel wrong"); // R7

  AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == MODE_NARROW) |-> (out_data[LO_W-1:0] == '0))
    else $error("narrow sample has low bits set"); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !cfg_error && wide_mode))
    else $error("reset state wrong"); // R8
endmodule

// File: tb/tb_mc_delay_line.sv
`timescale 1ns/1ps
module tb_mc_delay_line;
  localparam int LIMIT = 1008;
  localparam int HALF  = 504;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] cfg_delay = '0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_ch = '0;
  logic [31:0]  in_data = '0;
  logic         out_valid;
  logic [2:0]   out_ch;
  logic [31:0]  out_data;
  logic         wide_mode, cfg_error;

  always #2.5 clk = ~clk;

  mc_delay_line dut (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay),
    .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data),
    .wide_mode(wide_mode), .cfg_error(cfg_error)
  );

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [127:0] cfg;
    logic [7:0]   mask;
    logic [15:0]  nsamp;
    logic         wide;
  } row_t;

  localparam int NROWS = 5;
  localparam row_t ROWS [NROWS] = '{
    '{128'h0, 8'hFF, 16'd200, 1'b1},
    '{{16'd9, 16'd5, 16'd2, 16'd15, 16'd1, 16'd7, 16'd0, 16'd3}, 8'hFF, 16'd900, 1'b1},
    '{{16'd50, 16'd50, 16'd50, 16'd50, 16'd50, 16'd300, 16'd50, 16'd50}, 8'h24, 16'd900, 1'b0},
    '{{16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd496}, 8'h81, 16'd1300, 1'b1},
    '{{16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd497}, 8'h81, 16'd1300, 1'b0}
  };

  // bench model
  logic [31:0]  hist [8][2048];
  int           cnt [8];
  int           mn [8];
  bit           mwide = 1'b1;
  logic [127:0] cur_cfg = '0;
  logic [31:0]  seed = 32'h1234_5678;

  logic [2:0]  eq_ch [$];
  logic [31:0] eq_d  [$];
  bit          eq_chk [$];

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor (R1, R3, R7)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (eq_ch.size() == 0) begin
        check(1'b0, "R7 unexpected out_valid", 32'(out_ch), 32'hFFFF_FFFF);
      end else begin
        logic [2:0] ec;
        logic [31:0] ed;
        bit ek;
        ec = eq_ch.pop_front();
        ed = eq_d.pop_front();
        ek = eq_chk.pop_front();
        check(out_ch == ec, "R7 out_ch", 32'(out_ch), 32'(ec));
        if (ek) check(out_data == ed, "R1/R3 delayed data", out_data, ed);
      end
    end
  end

  // called at a negedge; returns at the next negedge
  task automatic send(input int ch, input logic [31:0] d);
    in_valid = 1'b1;
    in_ch = 3'(ch);
    in_data = d;
    eq_ch.push_back(3'(ch));
    if (cnt[ch] >= mn[ch] + 1) begin
      logic [31:0] old;
      old = hist[ch][(cnt[ch] - mn[ch] - 1) & 2047];
      eq_d.push_back(mwide ? old : (old & 32'hFFFF_C000));
      eq_chk.push_back(1'b1);
    end else begin
      eq_d.push_back('0);
      eq_chk.push_back(1'b0);
    end
    hist[ch][cnt[ch] & 2047] = d;
    cnt[ch]++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // apply a configuration; the model follows the R6/R9 acceptance rule
  task automatic set_cfg(input logic [127:0] c);
    int sum = 0;
    cfg_delay = c;
    for (int k = 0; k < 8; k++) sum += int'(c[k*16 +: 16]);
    if (sum < LIMIT) begin
      if (c != cur_cfg) begin
        for (int k = 0; k < 8; k++) cnt[k] = 0;
      end
      cur_cfg = c;
      for (int k = 0; k < 8; k++) mn[k] = int'(c[k*16 +: 16]);
      mwide = (sum < HALF);
    end
    @(negedge clk);
  endtask

  task automatic burst(input logic [7:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      int ch;
      ch = int'(rnd() >> 29);
      while (!mask[ch]) ch = int'(rnd() >> 29);
      send(ch, rnd());
    end
    idle(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      cnt[k] = 0;
      mn[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 out_valid after reset", 32'(out_valid), 32'h0);
    check(cfg_error == 1'b0, "R8 cfg_error after reset", 32'(cfg_error), 32'h0);
    check(wide_mode == 1'b1, "R8 wide_mode after reset", 32'(wide_mode), 32'h1);

    // R7: single sample latency of three edges
    send(3, 32'hA5A5_0001);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 no output after one edge", 32'(out_valid), 32'h0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 no output after two edges", 32'(out_valid), 32'h0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_ch == 3'd3, "R7 output after three edges",
          {28'h0, out_valid, out_ch}, 32'hB);
    idle(4);

    // table-driven scenarios: R1 R2 R3 R4 R5 R9
    for (int r = 0; r < NROWS; r++) begin
      set_cfg(ROWS[r].cfg);
      check(wide_mode == ROWS[r].wide, ROWS[r].wide ? "R4 wide flag" : "R5 narrow flag",
            32'(wide_mode), 32'(ROWS[r].wide));
      check(cfg_error == 1'b0, "R6 accepted config has no error", 32'(cfg_error), 32'h0);
      idle(1);
      burst(ROWS[r].mask, int'(ROWS[r].nsamp));
    end

    // R6: total equal to the limit is refused, old delays stay
    set_cfg({16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1001});
    check(cfg_error == 1'b1, "R6 limit refused", 32'(cfg_error), 32'h1);
    check(wide_mode == 1'b0, "R6 width kept", 32'(wide_mode), 32'h0);
    burst(8'h81, 1300);
    check(cfg_error == 1'b1, "R6 error held while refused", 32'(cfg_error), 32'h1);

    // R6: one below the limit is taken
    set_cfg({16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1000});
    check(cfg_error == 1'b0, "R6 one below limit accepted", 32'(cfg_error), 32'h0);
    check(wide_mode == 1'b0, "R5 narrow at large total", 32'(wide_mode), 32'h0);
    burst(8'h03, 2400);

    // R2: back to zero counts, one-sample delay on a single channel
    set_cfg(128'h0);
    check(wide_mode == 1'b1, "R4 wide again at zero total", 32'(wide_mode), 32'h1);
    idle(1);
    burst(8'h40, 40);

    check(eq_ch.size() == 0, "R7 every sample emerged", 32'(eq_ch.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule